// File: doc/BRIEF.md
# Interrupt Aggregator with Per-Channel Done-Overflow Detection

This block gathers every interrupt source of a processing engine into a single 64-bit status register and drives one interrupt line toward the host. The sources are four processing channels, a parameterised set of execution units and one internal-timeout indication. Each channel and each execution unit raises a one-cycle done pulse and a one-cycle error pulse. Each pulse latches a status bit. The bit stays set until the host writes a 1 to the same position of a write-only clear register.

Each channel also counts the done events that the host has not yet acknowledged. If a channel piles up more done events than the limit allows without a clear of its done bit, a dedicated overflow status bit for that channel latches. The host can then tell that done events were lost. A mask register selects which status bits may drive the interrupt line.

All three registers sit on a minimal register bus. The bus has a write strobe, a 2-bit address, 64-bit write data and combinational read data.

Top module: `irq_aggregator`

## Requirements
- R1: One cycle after a source pulses, its status bit reads 1. The bit positions are fixed. Execution unit e uses bit 2e for error and bit 2e+1 for done. The timeout uses bit 15. Channel c uses bit 20+c for overflow, bit 24+2c for error and bit 25+2c for done.
- R2: A status bit that is set stays set until reset or until the clear register is written with a 1 at its position. Writing 0 there, or writing other bits, leaves it unchanged.
- R3: If a source pulses in the same cycle as a clear of its bit, the bit reads 1 afterwards.
- R4: A channel's overflow bit latches on the 16th done pulse that arrives while no clear of that channel's done bit has taken place. The 15th such pulse does not set it.
- R5: A clear of a channel's done bit zeroes that channel's pending count. If a done pulse arrives in the same cycle, the count restarts at one, so the 15th later pulse raises overflow.
- R6: The pending count saturates after overflow. If the host clears only the overflow bit, further done pulses do not set it again until the channel's done bit has been cleared.
- R7: The interrupt output is 1 exactly when some status bit and the matching mask bit are both 1. It follows mask writes and status changes in the same cycle that the register updates.
- R8: Address 0 is the mask register (read/write). Address 1 is the status register (read-only). Address 2 is the clear register, which reads 0. Any other address reads 0. Bits assigned to no source always read 0 in mask and status and cannot be set.
- R9: After reset the mask and the status are all zero and the interrupt output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_done_i | input | NUM_CH | Per-channel done pulses |
| ch_err_i | input | NUM_CH | Per-channel error pulses |
| eu_done_i | input | NUM_EU | Per-execution-unit done pulses |
| eu_err_i | input | NUM_EU | Per-execution-unit error pulses |
| timeout_i | input | 1 | Internal timeout pulse |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 64 | Write data |
| bus_rdata_o | output | 64 | Read data (combinational) |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its defaults: four channels, six execution units and an overflow limit of 15. With these values every source bit and every gap between assigned fields lies within the register. An overflow needs only sixteen pulses, so the bench can drive a channel to overflow, past saturation and back after a clear many times over. With six execution units the reserved gaps stay large enough that an all-ones write shows that unassigned positions are discarded.

// File: rtl/irq_agg_pkg.sv
// Package irq_agg_pkg
// Holds the register addresses and the fixed bit positions of the
// aggregated status word. It assumes at most 4 channels and at most
// 7 execution units, so that the fields do not collide.
package irq_agg_pkg;
    localparam int REG_W    = 64;
    localparam int TMO_BIT  = 15;
    localparam int OVF_BASE = 20;
    localparam int CH_BASE  = 24;
    localparam int EU_BASE  = 0;

    typedef enum logic [1:0] {
        ADDR_MASK   = 2'd0,
        ADDR_STATUS = 2'd1,
        ADDR_CLEAR  = 2'd2
    } reg_addr_e;

    // Mask of the bits that belong to a source
    function automatic logic [REG_W-1:0] valid_bits(input int n_ch, input int n_eu);
        logic [REG_W-1:0] m;
        m = '0;
        m[TMO_BIT] = 1'b1;
        for (int c = 0; c < n_ch; c++) begin
            m[OVF_BASE + c]         = 1'b1;
            m[CH_BASE + 2*c]        = 1'b1;
            m[CH_BASE + 2*c + 1]    = 1'b1;
        end
        for (int e = 0; e < n_eu; e++) begin
            m[EU_BASE + 2*e]        = 1'b1;
            m[EU_BASE + 2*e + 1]    = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/irq_done_counter.sv
// Module irq_done_counter
// Counts the done events of one channel that the host has not yet
// acknowledged. It emits a one-cycle overflow pulse when the count
// would pass LIMIT, then saturates. A clear zeroes the count. A done
// event in the same cycle as the clear restarts the count at one.
module irq_done_counter #(
    parameter int LIMIT = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic done_i,
    input  logic clr_i,
    output logic ovf_o
);
    localparam int CNT_W = $clog2(LIMIT + 2);
    localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(LIMIT);
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(LIMIT + 1);

    logic [CNT_W-1:0] cnt_q;

    // Overflow fires on the done event that would pass the limit
    assign ovf_o = done_i && !clr_i && (cnt_q == CNT_LIM);

    // Pending-done count with clear, restart and saturation
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr_i)
            cnt_q <= done_i ? CNT_W'(1) : '0;
        else if (done_i && cnt_q != CNT_SAT)
            cnt_q <= cnt_q + CNT_W'(1);
    end

    AST_CLR_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q <= CNT_W'(1))); // R5
    AST_OVF_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> !ovf_o); // R6
endmodule

// File: rtl/irq_status_reg.sv
// Module irq_status_reg
// A sticky event register. An event sets its bit. Writing 1 to the
// clear mask drops the bit, but an event in the same cycle wins.
// Positions outside VALID never hold a 1.
module irq_status_reg #(
    parameter int W = 64,
    parameter logic [W-1:0] VALID = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] st_o
);
    logic [W-1:0] st_q;

    // Set on event, clear on request, event has priority
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= ((st_q & ~clr_i) | evt_i) & VALID;
    end

    assign st_o = st_q;

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_i & VALID) != '0) |=> ((st_q & $past(evt_i & VALID)) == $past(evt_i & VALID))); // R3
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i == '0) |=> ((st_q & $past(st_q)) == $past(st_q))); // R2
endmodule

// File: rtl/irq_aggregator.sv
// Module irq_aggregator
// Top level. It maps the sources onto the status word and keeps one
// pending-done counter per channel. It holds the mask register, decodes
// the register bus and combines the unmasked status into one interrupt.
// It assumes NUM_CH <= 4 and NUM_EU <= 7.
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int NUM_EU    = 6,
    parameter int OVF_LIMIT = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ch_done_i,
    input  logic [NUM_CH-1:0] ch_err_i,
    input  logic [NUM_EU-1:0] eu_done_i,
    input  logic [NUM_EU-1:0] eu_err_i,
    input  logic              timeout_i,
    input  logic              bus_wr_i,
    input  logic [1:0]        bus_addr_i,
    input  logic [63:0]       bus_wdata_i,
    output logic [63:0]       bus_rdata_o,
    output logic              irq_o
);
    localparam logic [REG_W-1:0] VALID = valid_bits(NUM_CH, NUM_EU);

    logic [REG_W-1:0]  mask_q;
    logic [REG_W-1:0]  status;
    logic [REG_W-1:0]  events;
    logic [REG_W-1:0]  clr_vec;
    logic [NUM_CH-1:0] ovf_evt;

    // Clear vector is live only during a write to the clear address
    assign clr_vec = (bus_wr_i && bus_addr_i == ADDR_CLEAR) ? bus_wdata_i : '0;

    // Place every source pulse on its status position
    always_comb begin
        events = '0;
        events[TMO_BIT] = timeout_i;
        for (int c = 0; c < NUM_CH; c++) begin
            events[OVF_BASE + c]      = ovf_evt[c];
            events[CH_BASE + 2*c]     = ch_err_i[c];
            events[CH_BASE + 2*c + 1] = ch_done_i[c];
        end
        for (int e = 0; e < NUM_EU; e++) begin
            events[EU_BASE + 2*e]     = eu_err_i[e];
            events[EU_BASE + 2*e + 1] = eu_done_i[e];
        end
    end

    // One pending-done counter per channel
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        irq_done_counter #(.LIMIT(OVF_LIMIT)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .done_i (ch_done_i[c]),
            .clr_i  (clr_vec[CH_BASE + 2*c + 1]),
            .ovf_o  (ovf_evt[c])
        );
    end

    irq_status_reg #(.W(REG_W), .VALID(VALID)) u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .evt_i (events),
        .clr_i (clr_vec),
        .st_o  (status)
    );

    // Mask register, only source positions are writable
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (bus_wr_i && bus_addr_i == ADDR_MASK)
            mask_q <= bus_wdata_i & VALID;
    end

    // Read mux
    always_comb begin
        case (bus_addr_i)
            ADDR_MASK:   bus_rdata_o = mask_q;
            ADDR_STATUS: bus_rdata_o = status;
            default:     bus_rdata_o = '0;
        endcase
    end

    // Combined interrupt
    assign irq_o = |(status & mask_q);

    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (mask_q != '0 && status != '0)); // R7
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rdata_o & ~VALID) == '0)); // R8
endmodule

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  ch_done = '0, ch_err = '0;
    logic [5:0]  eu_done = '0, eu_err = '0;
    logic        tmo = 1'b0;
    logic        wr = 1'b0;
    logic [1:0]  addr = 2'd1;
    logic [63:0] wdata = '0;
    logic [63:0] rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    localparam logic [63:0] VALID = 64'h0000_0000_FFF0_8FFF;

    always #(PERIOD/2) clk = ~clk;

    irq_aggregator #(.NUM_CH(4), .NUM_EU(6), .OVF_LIMIT(15)) u_dut (
        .clk(clk), .rst_n(rst_n), .ch_done_i(ch_done), .ch_err_i(ch_err),
        .eu_done_i(eu_done), .eu_err_i(eu_err), .timeout_i(tmo),
        .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .irq_o(irq)
    );

    typedef struct packed {
        logic [3:0]  chd;
        logic [3:0]  che;
        logic [5:0]  eud;
        logic [5:0]  eue;
        logic        tm;
        logic        w;
        logic [1:0]  a;
        logic [63:0] wd;
        logic [63:0] st;
        logic        ir;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{4'h0, 4'h0, 6'h00, 6'h00, 1'b0, 1'b1, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b0},
        '{4'h1, 4'h0, 6'h00, 6'h00, 1'b0, 1'b0, 2'd1, 64'h0, 64'h0200_0000, 1'b1},
        '{4'h0, 4'h0, 6'h00, 6'h04, 1'b0, 1'b0, 2'd1, 64'h0, 64'h0200_0010, 1'b1},
        '{4'h0, 4'h0, 6'h00, 6'h00, 1'b1, 1'b0, 2'd1, 64'h0, 64'h0200_8010, 1'b1},
        '{4'h0, 4'h0, 6'h00, 6'h00, 1'b0, 1'b1, 2'd2, 64'h0200_0000, 64'h0000_8010, 1'b1},
        '{4'h0, 4'h0, 6'h00, 6'h00, 1'b0, 1'b1, 2'd2, 64'h0000_8010, 64'h0, 1'b0},
        '{4'h0, 4'h8, 6'h00, 6'h00, 1'b0, 1'b0, 2'd1, 64'h0, 64'h4000_0000, 1'b1},
        '{4'h0, 4'h0, 6'h00, 6'h00, 1'b0, 1'b1, 2'd0, 64'h0, 64'h4000_0000, 1'b0},
        '{4'h0, 4'h8, 6'h00, 6'h00, 1'b0, 1'b1, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'h4000_0000, 1'b0},
        '{4'h0, 4'h0, 6'h00, 6'h00, 1'b0, 1'b1, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b0}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        ch_done = '0; ch_err = '0; eu_done = '0; eu_err = '0;
        tmo = 1'b0; wr = 1'b0; addr = 2'd1; wdata = '0;
        #1;
    endtask

    task automatic rd(input logic [1:0] a, output logic [63:0] d);
        addr = a;
        #1;
        d = rdata;
        addr = 2'd1;
    endtask

    task automatic wreg(input logic [1:0] a, input logic [63:0] d);
        wr = 1'b1; addr = a; wdata = d;
        tick();
    endtask

    task automatic pulses(input int ch, input int n);
        for (int i = 0; i < n; i++) begin
            ch_done[ch] = 1'b1;
            tick();
        end
    endtask

    initial begin
        #(PERIOD * 100000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [63:0] d;
        #1;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        #1;
        // R9 reset state
        rd(2'd0, d); check("R9 mask after reset", d, 64'h0);
        rd(2'd1, d); check("R9 status after reset", d, 64'h0);
        check("R9 irq after reset", {63'h0, irq}, 64'h0);

        // Table walk: R1 R2 R3 R7
        foreach (VECS[k]) begin
            ch_done = VECS[k].chd; ch_err = VECS[k].che;
            eu_done = VECS[k].eud; eu_err = VECS[k].eue;
            tmo = VECS[k].tm; wr = VECS[k].w; addr = VECS[k].a; wdata = VECS[k].wd;
            tick();
            rd(2'd1, d);
            check($sformatf("R1/R2/R3 vector %0d status", k), d, VECS[k].st);
            check($sformatf("R7 vector %0d irq", k), {63'h0, irq}, {63'h0, VECS[k].ir});
        end

        // R8 reserved bits and register reads
        wreg(2'd0, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(2'd0, d); check("R8 mask keeps only source bits", d, VALID);
        rd(2'd2, d); check("R8 clear register reads zero", d, 64'h0);
        rd(2'd3, d); check("R8 unused address reads zero", d, 64'h0);

        // R7 per-bit mask gating
        wreg(2'd0, 64'h0000_8000);
        eu_done[0] = 1'b1; tick();
        check("R7 masked source keeps irq low", {63'h0, irq}, 64'h0);
        tmo = 1'b1; tick();
        check("R7 enabled source raises irq", {63'h0, irq}, 64'h1);
        wreg(2'd0, 64'h0);
        check("R7 mask write drops irq", {63'h0, irq}, 64'h0);
        wreg(2'd2, 64'hFFFF_FFFF_FFFF_FFFF);

        // R4 overflow on the 16th pending done of channel 1 (bit 21)
        pulses(1, 15);
        rd(2'd1, d); check("R4 no overflow after 15", d & 64'h0020_0000, 64'h0);
        pulses(1, 1);
        rd(2'd1, d); check("R4 overflow after 16", d & 64'h0020_0000, 64'h0020_0000);
        check("R4 other channels stay clear", d & 64'h00D0_0000, 64'h0);

        // R6 saturation: clear overflow only, more pulses do not re-raise
        pulses(1, 5);
        wreg(2'd2, 64'h0020_0000);
        pulses(1, 16);
        rd(2'd1, d); check("R6 saturated count no re-raise", d & 64'h0020_0000, 64'h0);

        // R5 clear done bit (27) resets count
        wreg(2'd2, 64'h0800_0000);
        pulses(1, 15);
        rd(2'd1, d); check("R5 count restarts from zero", d & 64'h0020_0000, 64'h0);
        pulses(1, 1);
        rd(2'd1, d); check("R5 overflow after fresh 16", d & 64'h0020_0000, 64'h0020_0000);

        // R5 clear with same-cycle done restarts at one (channel 2, done bit 29, ovf bit 22)
        wreg(2'd2, 64'hFFFF_FFFF_FFFF_FFFF);
        pulses(2, 3);
        ch_done[2] = 1'b1; wr = 1'b1; addr = 2'd2; wdata = 64'h2000_0000; tick();
        rd(2'd1, d); check("R3 done bit survives same-cycle clear", d & 64'h2000_0000, 64'h2000_0000);
        pulses(2, 14);
        rd(2'd1, d); check("R5 no overflow at 15 pending", d & 64'h0040_0000, 64'h0);
        pulses(2, 1);
        rd(2'd1, d); check("R5 overflow at 16 pending", d & 64'h0040_0000, 64'h0040_0000);

        // R9 reset mid-run clears everything
        wreg(2'd0, 64'hFFFF_FFFF_FFFF_FFFF);
        rst_n = 1'b0; tick(); rst_n = 1'b1; #1;
        rd(2'd1, d); check("R9 status cleared by reset", d, 64'h0);
        rd(2'd0, d); check("R9 mask cleared by reset", d, 64'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule